// File: doc/BRIEF.md
# External Interrupt Sense Detector

This block turns four asynchronous external interrupt pins into four request outputs. Each pin has its own 2-bit sense code that selects one of four conditions: a low level, a falling edge, a rising edge, or either edge. All four codes sit in one 16-bit control word on a small register bus. Each pin is first brought into the clock domain through two flops. Edges are found by comparing the synchronized value with its value one clock earlier.

In level mode the request output simply follows the inverted synchronized pin. In any edge mode, a detected edge sets a sticky flag. The flag drives the request until software writes a 1 to that pin's bit at the flag-clear address. If a new edge lands in the same cycle as a clear, the flag stays set. A change of sense code blanks edge detection for that one cycle, so reconfiguration cannot report a phantom edge. Reading the flag-clear address returns the current request vector.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control word reads 0x0000 (all pins in low-level mode), the status word reads 0x0000, and with all pins held high every request output is 0.
- R2: Control bits 15:8 always read as 0, and writing ones to them has no effect.
- R3: A write to address 0 loads bits 7:0 of the control word, and pin n takes its sense code from bits [2n+1:2n].
- R4: Sense code 00 raises request n while the synchronized pin n is low. The request appears two clock edges after the pin falls and drops again when the pin returns high, without latching.
- R5: Sense code 01 sets pin n's sticky flag on a falling edge, three clock edges after the pin changes. A rising edge does not set it.
- R6: Sense code 10 sets the sticky flag on a rising edge only.
- R7: Sense code 11 sets the sticky flag on both falling and rising edges.
- R8: In an edge mode, request n stays 1 until a bus write to address 1 carries a 1 in bit n. Bits written as 0 leave their flags unchanged.
- R9: An edge detected in the same cycle as a clear of that pin leaves the flag set.
- R10: Changing a pin's sense code while its pin is stable never sets that pin's flag.
- R11: A read of address 1 returns the four request outputs in bits 3:0, with bits 15:4 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| irq_pin | input | 4 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 flag clear / status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq_req | output | 4 | Per-pin request state |

## Verification
An edge on a pin and a software clear of that same pin's flag can meet in one clock. That cycle is provoked as follows. A flag is first set and the pin returned high. The pin is then dropped at a falling clock edge, and the bench counts the two synchronizer stages. The clear write is placed so that it is sampled on exactly the edge at which the falling transition reaches the edge comparator. The outcome is judged at the ports: the request must still read 1 afterwards. A separate clear with no coincident edge must bring it to 0.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  localparam int unsigned SENSE_W = 2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_ANY  = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {WIDTH{RST_VAL}};
      stage2_q <= {WIDTH{RST_VAL}};
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;

endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
  import irq_sense_pkg::*;
#(
  parameter int unsigned N_PINS = 4,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned AW     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [AW-1:0]                   bus_addr,
  input  logic [REG_W-1:0]                bus_wdata,
  output logic [REG_W-1:0]                bus_rdata,
  input  logic [N_PINS-1:0]               req_in,
  output logic [N_PINS-1:0][SENSE_W-1:0]  mode_out,
  output logic [N_PINS-1:0]               clr_out
);

  localparam int unsigned CFG_W = N_PINS * SENSE_W;

  logic [CFG_W-1:0] ctrl_q;
  logic [CFG_W-1:0] ctrl_d;
  logic             ctrl_en;
  logic             hit_ctrl;
  logic             hit_flag;

  always_comb begin
    hit_ctrl = (bus_addr == AW'(ADDR_CTRL));
    hit_flag = (bus_addr == AW'(ADDR_FLAG));
    ctrl_en  = bus_sel & bus_wr & hit_ctrl;
    ctrl_d   = bus_wdata[CFG_W-1:0];
    clr_out  = (bus_sel & bus_wr & hit_flag) ? bus_wdata[N_PINS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar n = 0; n < N_PINS; n++) begin : g_field
    assign mode_out[n] = ctrl_q[n*SENSE_W +: SENSE_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[CFG_W-1:0] = ctrl_q;
    end else if (hit_flag) begin
      bus_rdata[N_PINS-1:0] = req_in;
    end
  end

  assert_ctrl_load_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(ADDR_CTRL)) |=> ctrl_q == $past(bus_wdata[CFG_W-1:0]));

  assert_reserved_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(ADDR_CTRL)) |-> bus_rdata[REG_W-1:CFG_W] == '0);

endmodule

// File: rtl/irq_sense_chan.sv
module irq_sense_chan
  import irq_sense_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_sync,
  input  logic [SENSE_W-1:0] mode,
  input  logic               clr,
  output logic               req
);

  logic               prev_q;
  logic               prev_d;
  logic [SENSE_W-1:0] mode_q;
  logic               flag_q;
  logic               flag_d;
  logic               flag_en;
  logic               mode_chg;
  logic               fell;
  logic               rose;
  logic               hit;

  always_comb begin
    mode_chg = (mode != mode_q);
    fell     = prev_q & ~pin_sync;
    rose     = ~prev_q & pin_sync;
    unique case (sense_e'(mode))
      SENSE_FALL: hit = fell;
      SENSE_RISE: hit = rose;
      SENSE_ANY:  hit = fell | rose;
      default:    hit = 1'b0;
    endcase
    if (mode_chg) hit = 1'b0;
    prev_d  = pin_sync;
    flag_en = clr | hit;
    flag_d  = hit ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      mode_q <= '0;
    end else begin
      prev_q <= prev_d;
      mode_q <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign req = (sense_e'(mode) == SENSE_LOW) ? ~pin_sync : flag_q;

  assert_edge_sets_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  assert_edge_beats_clear_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> flag_q);

  assert_clear_drops_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q);

  assert_no_reconfig_edge_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> !$rose(flag_q));

  assert_flag_from_pin_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(prev_q != pin_sync));

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import irq_sense_pkg::*;
#(
  parameter int unsigned N_PINS = 4,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] irq_pin,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [N_PINS-1:0] irq_req
);

  logic [N_PINS-1:0]              pin_s;
  logic [N_PINS-1:0][SENSE_W-1:0] mode;
  logic [N_PINS-1:0]              clr;

  irq_sync #(.WIDTH(N_PINS), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (irq_pin),
    .q_sync  (pin_s)
  );

  irq_sense_regs #(.N_PINS(N_PINS), .REG_W(REG_W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_in    (irq_req),
    .mode_out  (mode),
    .clr_out   (clr)
  );

  for (genvar n = 0; n < N_PINS; n++) begin : g_chan
    irq_sense_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_s[n]),
      .mode     (mode[n]),
      .clr      (clr[n]),
      .req      (irq_req[n])
    );
  end

  assert_level_when_low_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] == SENSE_LOW && !pin_s[0]) |-> irq_req[0]);

endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;

  logic        clk;
  logic        rst_n;
  logic [3:0]  irq_pin;
  logic        bus_sel;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_req;

  int n_tests;
  int n_fail;
  bit done;

  ext_irq_sense u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pin   (irq_pin),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    bus_read(2'd0, v); check("R1 ctrl after reset", v, 16'h0000);
    bus_read(2'd1, v); check("R1 status after reset", v, 16'h0000);
    check("R1 requests after reset", {12'h0, irq_req}, 16'h0000);
  endtask

  task automatic t_reserved;
    logic [15:0] v;
    bus_write(2'd0, 16'hFFFF);
    bus_read(2'd0, v); check("R2 reserved bits read 0", v, 16'h00FF);
    bus_write(2'd0, 16'hA5C3);
    bus_read(2'd0, v); check("R3 low byte loaded", v, 16'h00C3);
    bus_write(2'd0, 16'h0000);
    tick(1);
  endtask

  task automatic t_level;
    irq_pin[0] = 1'b0;
    tick(1); check("R4 level latency one edge", {15'h0, irq_req[0]}, 16'h0);
    tick(1); check("R4 level asserted", {15'h0, irq_req[0]}, 16'h1);
    irq_pin[0] = 1'b1;
    tick(2); check("R4 level not latched", {15'h0, irq_req[0]}, 16'h0);
  endtask

  task automatic t_fall;
    bus_write(2'd0, 16'h0004); // pin1 = 01
    tick(1);
    irq_pin[1] = 1'b0;
    tick(3); check("R5 falling edge sets flag", {15'h0, irq_req[1]}, 16'h1);
    bus_write(2'd1, 16'h0002);
    check("R8 clear drops flag", {15'h0, irq_req[1]}, 16'h0);
    irq_pin[1] = 1'b1;
    tick(4); check("R5 rising edge ignored", {15'h0, irq_req[1]}, 16'h0);
  endtask

  task automatic t_rise;
    bus_write(2'd0, 16'h0020); // pin2 = 10
    tick(1);
    irq_pin[2] = 1'b0;
    tick(4); check("R6 falling edge ignored", {15'h0, irq_req[2]}, 16'h0);
    irq_pin[2] = 1'b1;
    tick(3); check("R6 rising edge sets flag", {15'h0, irq_req[2]}, 16'h1);
    bus_write(2'd1, 16'h0004);
    check("R6 cleared", {15'h0, irq_req[2]}, 16'h0);
  endtask

  task automatic t_both;
    bus_write(2'd0, 16'h00C0); // pin3 = 11
    tick(1);
    irq_pin[3] = 1'b0;
    tick(3); check("R7 falling edge sets flag", {15'h0, irq_req[3]}, 16'h1);
    bus_write(2'd1, 16'h0008);
    check("R7 cleared", {15'h0, irq_req[3]}, 16'h0);
    irq_pin[3] = 1'b1;
    tick(3); check("R7 rising edge sets flag", {15'h0, irq_req[3]}, 16'h1);
    bus_write(2'd1, 16'h0008);
  endtask

  task automatic t_clear_select;
    logic [15:0] v;
    bus_write(2'd0, 16'h0044); // pin1 and pin3 = 01
    tick(1);
    irq_pin[1] = 1'b0; irq_pin[3] = 1'b0;
    tick(3); check("R8 both flags set", {12'h0, irq_req}, 16'h000A);
    bus_write(2'd1, 16'h0000);
    check("R8 zero write keeps flags", {12'h0, irq_req}, 16'h000A);
    bus_write(2'd1, 16'h0008);
    check("R8 only pin3 cleared", {12'h0, irq_req}, 16'h0002);
    bus_read(2'd1, v); check("R11 status read", v, 16'h0002);
    bus_write(2'd1, 16'h0002);
    irq_pin[1] = 1'b1; irq_pin[3] = 1'b1;
    tick(4);
  endtask

  task automatic t_coincide;
    bus_write(2'd0, 16'h0004); // pin1 = 01
    tick(1);
    irq_pin[1] = 1'b0;
    tick(3);
    irq_pin[1] = 1'b1;
    tick(3); check("R9 flag set before clash", {15'h0, irq_req[1]}, 16'h1);
    irq_pin[1] = 1'b0;
    tick(2);                     // edge reaches comparator
    bus_write(2'd1, 16'h0002);   // clear sampled on the same edge
    check("R9 edge wins over clear", {15'h0, irq_req[1]}, 16'h1);
    bus_write(2'd1, 16'h0002);
    check("R9 later clear works", {15'h0, irq_req[1]}, 16'h0);
    irq_pin[1] = 1'b1;
    tick(4);
  endtask

  task automatic t_reconfig;
    bus_write(2'd0, 16'h0000);
    irq_pin[0] = 1'b0;
    tick(3); check("R10 level request while low", {15'h0, irq_req[0]}, 16'h1);
    bus_write(2'd0, 16'h0001); // pin0 -> falling
    tick(3); check("R10 no edge on switch to falling", {15'h0, irq_req[0]}, 16'h0);
    bus_write(2'd0, 16'h0003); // pin0 -> both
    tick(3); check("R10 no edge on switch to both", {15'h0, irq_req[0]}, 16'h0);
    irq_pin[0] = 1'b1;
    tick(3); check("R10 real edge still seen", {15'h0, irq_req[0]}, 16'h1);
    bus_write(2'd1, 16'h0001);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    irq_pin = 4'hF; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_reserved();
    t_level();
    t_fall();
    t_rise();
    t_both();
    t_clear_select();
    t_coincide();
    t_reconfig();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule